// File: doc/BRIEF.md
# LIN Frame Response Engine

This block is the byte-level part of a LIN controller. It sits between a UART-style serializer, which moves single bytes over the bus, and the controller logic that configures each frame. It deals with only two parts of a frame: the protected identifier and the response field. Break and sync generation, bit timing, baud detection and wake-up are handled elsewhere.

When `is_master` is set, a frame starts by sending the 6-bit identifier with its two parity bits attached. When `is_master` is clear, the block waits for the identifier byte from the serializer and checks its parity. The node action captured at frame start then decides what happens to the response:
- In publish, data bytes taken from a local source stream are forwarded to the serializer, followed by a generated checksum byte.
- In subscribe, bytes are taken from the serializer, handed out on a local output, and the trailing checksum byte is verified.
- In ignore, the response is skipped.

Parity handling can be switched off, and so can checksum handling. The checksum can be classic or enhanced. Errors are held in sticky flags until they are cleared. A one-cycle done pulse marks the end of each complete frame.

Top module: `lin_resp_engine`

## Requirements
- R1: After synchronous reset the engine is idle: `tx_valid`, `rx_ready`, `pub_ready`, `sub_valid`, `frame_done`, `err_parity` and `err_csum` are all 0.
- R2: With `is_master`=1 and `parity_off`=0, the first byte offered on the tx stream after `frame_start` is the identifier. Bits 5:0 hold the identifier. Bit 6 is id0^id1^id2^id4. Bit 7 is the inverse of id1^id3^id4^id5. While `tx_ready` is low, the byte stays offered and unchanged.
- R3: With `parity_off`=1, a master sends the identifier with bits 7:6 equal to 0, and a received identifier is never checked for parity.
- R4: With `is_master`=0 and `parity_off`=0, the first rx byte is taken as the identifier. If its bits 7:6 do not match the R2 parity, `err_parity` is set, the frame ends without a response and `frame_done` stays low.
- R5: With node action 0 (publish), the response data bytes are forwarded one by one from the pub stream to the tx stream after the identifier. When the checksum is enabled, the checksum byte follows them.
- R6: The checksum is the 8-bit sum of the covered bytes, with each carry out of bit 7 added back in, and the result inverted. With `csum_classic`=0 (enhanced) the covered bytes are the protected identifier byte plus the data. With `csum_classic`=1 (classic) they are the data only.
- R7: With node action 1 (subscribe), the response data bytes are accepted from the rx stream and shown on `sub_data` with a `sub_valid` pulse. The next rx byte is compared with the R6 checksum, and a mismatch sets `err_csum`.
- R8: With `csum_off`=1, no checksum byte is sent or expected, and the frame completes after the last data byte.
- R9: With node action 2 or 3 (ignore), no response byte is sent or accepted, and the frame completes right after the identifier byte.
- R10: `frame_done` is high for exactly one cycle. That cycle is the one right after the clock edge that completes the final byte handshake of the frame.
- R11: `err_parity` and `err_csum` stay set until `err_clear` is high at a clock edge. A new error arriving in the same cycle as the clear wins.
- R12: `abort` returns the engine to idle at the next edge, with no done pulse and no further byte offered or accepted.
- R13: The response length is sampled from `byte_cnt` at `frame_start`. A value of 0 is treated as 1, and values above 8 are treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a frame when idle; samples the configuration |
| abort | input | 1 | Returns the engine to idle |
| is_master | input | 1 | 1: send the identifier; 0: receive it |
| id_in | input | 6 | Frame identifier (master) |
| node_act | input | 2 | 0 publish, 1 subscribe, 2/3 ignore |
| byte_cnt | input | 4 | Response data length, 1 to 8 |
| csum_classic | input | 1 | 1: classic checksum; 0: enhanced |
| csum_off | input | 1 | Disables all checksum handling |
| parity_off | input | 1 | Disables all identifier parity handling |
| tx_data | output | 8 | Byte to the serializer |
| tx_valid | output | 1 | tx byte offered |
| tx_ready | input | 1 | Serializer takes the tx byte |
| rx_data | input | 8 | Byte from the serializer |
| rx_valid | input | 1 | rx byte offered |
| rx_ready | output | 1 | Engine takes the rx byte |
| pub_data | input | 8 | Local response data to publish |
| pub_valid | input | 1 | Publish byte offered |
| pub_ready | output | 1 | Publish byte taken |
| sub_data | output | 8 | Received response data byte |
| sub_valid | output | 1 | sub_data is a new received byte |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| err_clear | input | 1 | Clears both error flags |
| err_parity | output | 1 | Sticky identifier parity error |
| err_csum | output | 1 | Sticky checksum mismatch |

## Verification
The hardest situations to reach are an error or an abort that lands partway through a frame, because they depend on where the frame has got to. The bench drives every serializer handshake one byte at a time, so it can decide exactly which byte of the frame carries the fault. It feeds a slave an identifier with one parity bit flipped and then confirms that the frame stops with no done pulse. It passes a checksum byte with its low bit flipped and confirms that `err_csum` latches. It raises `abort` after the first publish byte has been taken and confirms that both streams go silent. It also holds `tx_ready` low on the identifier byte to show that the offer is held steady.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_W   = 6;

    typedef enum logic [1:0] {
        ACT_PUBLISH   = 2'd0,
        ACT_SUBSCRIBE = 2'd1,
        ACT_IGNORE    = 2'd2,
        ACT_IGNORE_B  = 2'd3
    } node_act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_PID,
        ST_RX_PID,
        ST_TX_DATA,
        ST_TX_CSUM,
        ST_RX_DATA,
        ST_RX_CSUM,
        ST_DONE
    } eng_state_e;

    typedef struct packed {
        logic      master;
        node_act_e act;
        logic      classic;
        logic      csum_off;
        logic      parity_off;
    } frame_cfg_t;

    // Two identifier protection bits: {p1, p0}
    function automatic logic [1:0] pid_bits(input logic [ID_W-1:0] id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0};
    endfunction

    // Add with end-around carry
    function automatic logic [BYTE_W-1:0] csum_add(input logic [BYTE_W-1:0] a,
                                                   input logic [BYTE_W-1:0] b);
        logic [BYTE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
    endfunction

endpackage

// File: rtl/lin_pid_unit.sv
module lin_pid_unit
    import lin_resp_pkg::*;
(
    input  logic [ID_W-1:0]   id,
    input  logic              parity_off,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] pid_tx,
    output logic              rx_par_ok
);
    logic [1:0] rx_expect;

    always_comb begin
        pid_tx    = parity_off ? {2'b00, id} : {pid_bits(id), id};
        rx_expect = pid_bits(rx_byte[ID_W-1:0]);
        rx_par_ok = (rx_byte[BYTE_W-1:ID_W] == rx_expect);
    end
endmodule

// File: rtl/lin_csum_acc.sv
module lin_csum_acc
    import lin_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [BYTE_W-1:0] init_val,
    input  logic              add_en,
    input  logic [BYTE_W-1:0] add_byte,
    output logic [BYTE_W-1:0] csum_byte
);
    logic [BYTE_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst)         acc <= '0;
        else if (init)   acc <= init_val;
        else if (add_en) acc <= csum_add(acc, add_byte);
    end

    assign csum_byte = ~acc;

    // R6: a zero byte adds nothing to an end-around-carry sum
    assert_zero_add_R6: assert property (@(posedge clk) disable iff (rst)
        (add_en && !init && add_byte == '0) |=> (csum_byte == $past(csum_byte)));
endmodule

// File: rtl/lin_err_flags.sv
module lin_err_flags #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] set_vec,
    input  logic                 clear,
    output logic [NUM_FLAGS-1:0] flags
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags[g] <= 1'b0;
            else if (set_vec[g]) flags[g] <= 1'b1;
            else if (clear)      flags[g] <= 1'b0;
        end

        assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
            (flags[g] && !clear) |=> flags[g]);
        assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
            set_vec[g] |=> flags[g]);
    end
endmodule

// File: rtl/lin_frame_fsm.sv
module lin_frame_fsm
    import lin_resp_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              abort,
    input  frame_cfg_t        cfg_in,
    input  logic [ID_W-1:0]   id_in,
    input  logic [CNT_W-1:0]  byte_cnt,
    output logic [ID_W-1:0]   id_q,
    output logic              parity_off_q,
    input  logic [BYTE_W-1:0] pid_tx,
    input  logic              rx_par_ok,
    input  logic [BYTE_W-1:0] csum_byte,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] pub_data,
    input  logic              pub_valid,
    output logic              pub_ready,
    output logic [BYTE_W-1:0] sub_data,
    output logic              sub_valid,
    output logic              frame_done,
    output logic              acc_init,
    output logic [BYTE_W-1:0] acc_init_val,
    output logic              acc_add,
    output logic [BYTE_W-1:0] acc_byte,
    output logic              par_fail,
    output logic              cs_fail
);
    eng_state_e        st, st_nx;
    frame_cfg_t        cfg_q;
    logic [CNT_W-1:0]  remain;
    logic [CNT_W-1:0]  cnt_clamped;
    logic              tx_fire, rx_fire, own_tx;
    eng_state_e        resp_st;

    always_comb begin
        if (byte_cnt == '0)                    cnt_clamped = CNT_W'(1);
        else if (byte_cnt > CNT_W'(MAX_BYTES)) cnt_clamped = CNT_W'(MAX_BYTES);
        else                                   cnt_clamped = byte_cnt;
    end

    always_comb begin
        unique case (cfg_q.act)
            ACT_PUBLISH:   resp_st = ST_TX_DATA;
            ACT_SUBSCRIBE: resp_st = ST_RX_DATA;
            default:       resp_st = ST_DONE;
        endcase
    end

    always_comb begin
        own_tx    = (st == ST_TX_PID) || (st == ST_TX_CSUM);
        tx_valid  = own_tx || ((st == ST_TX_DATA) && pub_valid);
        tx_data   = (st == ST_TX_PID)  ? pid_tx :
                    (st == ST_TX_CSUM) ? csum_byte : pub_data;
        pub_ready = (st == ST_TX_DATA) && tx_ready;
        rx_ready  = (st == ST_RX_PID) || (st == ST_RX_DATA) || (st == ST_RX_CSUM);
        sub_valid = (st == ST_RX_DATA) && rx_valid;
        sub_data  = rx_data;
        frame_done = (st == ST_DONE);
        tx_fire   = tx_valid && tx_ready;
        rx_fire   = rx_valid && rx_ready;

        acc_init     = ((st == ST_TX_PID) && tx_fire) || ((st == ST_RX_PID) && rx_fire);
        acc_init_val = cfg_q.classic ? '0 : ((st == ST_TX_PID) ? pid_tx : rx_data);
        acc_add      = ((st == ST_TX_DATA) && tx_fire) || ((st == ST_RX_DATA) && rx_fire);
        acc_byte     = (st == ST_TX_DATA) ? pub_data : rx_data;

        par_fail = (st == ST_RX_PID) && rx_fire && !cfg_q.parity_off && !rx_par_ok;
        cs_fail  = (st == ST_RX_CSUM) && rx_fire && (rx_data != csum_byte);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (frame_start) st_nx = cfg_in.master ? ST_TX_PID : ST_RX_PID;
            ST_TX_PID:  if (tx_fire) st_nx = resp_st;
            ST_RX_PID:  if (rx_fire) st_nx = par_fail ? ST_IDLE : resp_st;
            ST_TX_DATA: if (tx_fire && remain == CNT_W'(1))
                            st_nx = cfg_q.csum_off ? ST_DONE : ST_TX_CSUM;
            ST_RX_DATA: if (rx_fire && remain == CNT_W'(1))
                            st_nx = cfg_q.csum_off ? ST_DONE : ST_RX_CSUM;
            ST_TX_CSUM: if (tx_fire) st_nx = ST_DONE;
            ST_RX_CSUM: if (rx_fire) st_nx = ST_DONE;
            ST_DONE:    st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
        if (abort) st_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cfg_q  <= '0;
            id_q   <= '0;
            remain <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && frame_start) begin
                cfg_q  <= cfg_in;
                id_q   <= id_in;
                remain <= cnt_clamped;
            end else if (acc_add) begin
                remain <= remain - CNT_W'(1);
            end
        end
    end

    assign parity_off_q = cfg_q.parity_off;

    // R2: an engine-owned byte stays offered and unchanged while stalled
    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (own_tx && !tx_ready && !abort) |=> (tx_valid && $stable(tx_data)));
    // R9: never sending and receiving at once
    assert_one_dir_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_valid, rx_ready}));
    // R10: done is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
    // R12: abort silences both streams
    assert_abort_idle_R12: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!tx_valid && !rx_ready && !frame_done));
    // R4: a parity failure ends the frame without a done pulse
    assert_par_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (par_fail && !abort) |=> (!frame_done && !rx_ready && !tx_valid));
endmodule

// File: rtl/lin_resp_engine.sv
module lin_resp_engine
    import lin_resp_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              abort,
    input  logic              is_master,
    input  logic [5:0]        id_in,
    input  logic [1:0]        node_act,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              csum_classic,
    input  logic              csum_off,
    input  logic              parity_off,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        pub_data,
    input  logic              pub_valid,
    output logic              pub_ready,
    output logic [7:0]        sub_data,
    output logic              sub_valid,
    output logic              frame_done,
    input  logic              err_clear,
    output logic              err_parity,
    output logic              err_csum
);
    frame_cfg_t        cfg_in;
    logic [ID_W-1:0]   id_q;
    logic              parity_off_q;
    logic [BYTE_W-1:0] pid_tx, csum_byte, acc_init_val, acc_byte;
    logic              rx_par_ok, acc_init, acc_add, par_fail, cs_fail;
    logic [1:0]        err_flags;

    always_comb begin
        cfg_in.master     = is_master;
        cfg_in.act        = node_act_e'(node_act);
        cfg_in.classic    = csum_classic;
        cfg_in.csum_off   = csum_off;
        cfg_in.parity_off = parity_off;
    end

    lin_pid_unit u_pid (
        .id         (id_q),
        .parity_off (parity_off_q),
        .rx_byte    (rx_data),
        .pid_tx     (pid_tx),
        .rx_par_ok  (rx_par_ok)
    );

    lin_csum_acc u_csum (
        .clk       (clk),
        .rst       (rst),
        .init      (acc_init),
        .init_val  (acc_init_val),
        .add_en    (acc_add),
        .add_byte  (acc_byte),
        .csum_byte (csum_byte)
    );

    lin_frame_fsm #(.MAX_BYTES(MAX_BYTES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .abort        (abort),
        .cfg_in       (cfg_in),
        .id_in        (id_in),
        .byte_cnt     (byte_cnt),
        .id_q         (id_q),
        .parity_off_q (parity_off_q),
        .pid_tx       (pid_tx),
        .rx_par_ok    (rx_par_ok),
        .csum_byte    (csum_byte),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .pub_data     (pub_data),
        .pub_valid    (pub_valid),
        .pub_ready    (pub_ready),
        .sub_data     (sub_data),
        .sub_valid    (sub_valid),
        .frame_done   (frame_done),
        .acc_init     (acc_init),
        .acc_init_val (acc_init_val),
        .acc_add      (acc_add),
        .acc_byte     (acc_byte),
        .par_fail     (par_fail),
        .cs_fail      (cs_fail)
    );

    lin_err_flags #(.NUM_FLAGS(2)) u_err (
        .clk     (clk),
        .rst     (rst),
        .set_vec ({cs_fail, par_fail}),
        .clear   (err_clear),
        .flags   (err_flags)
    );

    assign err_parity = err_flags[0];
    assign err_csum   = err_flags[1];
endmodule

// File: tb/sim_lin_resp_engine.sv
module sim_lin_resp_engine;
    logic       clk = 1'b0;
    logic       rst, frame_start, abort, is_master, csum_classic, csum_off, parity_off;
    logic [5:0] id_in;
    logic [1:0] node_act;
    logic [3:0] byte_cnt;
    logic [7:0] tx_data, rx_data, pub_data, sub_data;
    logic       tx_valid, tx_ready, rx_valid, rx_ready, pub_valid, pub_ready, sub_valid;
    logic       frame_done, err_clear, err_parity, err_csum;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lin_resp_engine u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_pid(input logic [5:0] id);
        logic a, b;
        a = id[0] ^ id[1] ^ id[2] ^ id[4];
        b = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {b, a, id};
    endfunction

    function automatic logic [7:0] ref_csum(input logic [7:0] pid, input bit classic,
                                            input logic [7:0] d [8], input int n);
        int s;
        s = classic ? 0 : int'(pid);
        for (int i = 0; i < n; i++) begin
            s = s + int'(d[i]);
            if (s > 255) s = s - 255;
        end
        return ~(s[7:0]);
    endfunction

    task automatic start_frame(input bit m, input logic [5:0] id, input logic [1:0] act,
                               input logic [3:0] cnt, input bit cl, input bit co, input bit po);
        @(negedge clk);
        is_master = m; id_in = id; node_act = act; byte_cnt = cnt;
        csum_classic = cl; csum_off = co; parity_off = po; frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
    endtask

    task automatic tx_step(input logic [7:0] exp, input string tag);
        @(negedge clk); pub_valid = 1'b0; #1;
        chk(tx_valid && tx_data == exp, tag, tx_data, exp);
    endtask

    task automatic pub_step(input logic [7:0] d, input string tag);
        @(negedge clk); pub_data = d; pub_valid = 1'b1; #1;
        chk(tx_valid && pub_ready && tx_data == d, tag, tx_data, d);
    endtask

    task automatic rx_step(input logic [7:0] b, input bit exp_sub, input string tag);
        @(negedge clk); rx_data = b; rx_valid = 1'b1; #1;
        if (exp_sub) chk(rx_ready && sub_valid && sub_data == b, tag, sub_data, b);
        else         chk(rx_ready && !sub_valid, tag, {rx_ready, sub_valid}, 2'b10);
    endtask

    task automatic done_step(input string tag);
        @(negedge clk); rx_valid = 1'b0; pub_valid = 1'b0; #1;
        chk(frame_done == 1'b1, {tag, " done high"}, frame_done, 1);
        @(negedge clk); #1;
        chk(!frame_done && !tx_valid && !rx_ready, {tag, " done single"},
            {frame_done, tx_valid, rx_ready}, 0);
    endtask

    task automatic clear_errors();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask

    function automatic void fill(output logic [7:0] d [8], input int seed);
        for (int i = 0; i < 8; i++) d[i] = 8'(8'hC5 + i * 53 + seed);
    endfunction

    task automatic run_pub(input logic [5:0] id, input logic [3:0] cnt, input int n,
                           input bit cl, input bit co, input bit po, input string tag);
        logic [7:0] d [8];
        logic [7:0] pid;
        fill(d, int'(id));
        pid = po ? {2'b00, id} : ref_pid(id);
        start_frame(1'b1, id, 2'd0, cnt, cl, co, po);
        tx_step(pid, {tag, " pid"});
        for (int i = 0; i < n; i++) pub_step(d[i], {tag, " data"});
        if (!co) tx_step(ref_csum(pid, cl, d, n), {tag, " csum"});
        done_step(tag);
    endtask

    task automatic run_sub(input logic [5:0] id, input logic [3:0] cnt, input int n,
                           input bit cl, input bit co, input bit bad, input string tag);
        logic [7:0] d [8];
        logic [7:0] pid;
        logic [7:0] cs;
        fill(d, int'(id) + 7);
        pid = ref_pid(id);
        cs  = ref_csum(pid, cl, d, n);
        start_frame(1'b0, 6'd0, 2'd1, cnt, cl, co, 1'b0);
        rx_step(pid, 1'b0, {tag, " pid"});
        for (int i = 0; i < n; i++) rx_step(d[i], 1'b1, {tag, " data"});
        if (!co) rx_step(bad ? (cs ^ 8'h01) : cs, 1'b0, {tag, " csum"});
        done_step(tag);
        chk(err_csum == bad, {tag, " err_csum"}, err_csum, bad);
        chk(!err_parity, {tag, " no parity err"}, err_parity, 0);
    endtask

    // R1
    task automatic t_reset();
        #1;
        chk(!tx_valid && !rx_ready && !pub_ready && !sub_valid && !frame_done
            && !err_parity && !err_csum, "R1 reset state",
            {tx_valid, rx_ready, pub_ready, sub_valid, frame_done, err_parity, err_csum}, 0);
    endtask

    // R2 stall hold, R9 master ignore
    task automatic t_pid_stall();
        logic [7:0] pid;
        pid = ref_pid(6'h2A);
        start_frame(1'b1, 6'h2A, 2'd2, 4'd3, 1'b0, 1'b0, 1'b0);
        @(negedge clk); tx_ready = 1'b0; #1;
        chk(tx_valid && tx_data == pid, "R2 pid offered", tx_data, pid);
        @(negedge clk); #1;
        chk(tx_valid && tx_data == pid, "R2 pid held under stall", tx_data, pid);
        @(negedge clk); tx_ready = 1'b1; #1;
        chk(tx_valid && tx_data == pid, "R2 pid after stall", tx_data, pid);
        done_step("R9 master ignore");
    endtask

    // R4
    task automatic t_bad_parity();
        logic [7:0] pid;
        pid = ref_pid(6'h15) ^ 8'h80;
        start_frame(1'b0, 6'd0, 2'd1, 4'd2, 1'b0, 1'b0, 1'b0);
        rx_step(pid, 1'b0, "R4 pid");
        @(negedge clk); rx_valid = 1'b0; #1;
        chk(err_parity && !rx_ready && !frame_done, "R4 parity error stops frame",
            {err_parity, rx_ready, frame_done}, 3'b100);
        @(negedge clk); #1;
        chk(!frame_done && !rx_ready, "R4 no done later", {frame_done, rx_ready}, 0);
        // R11 sticky across cycles
        repeat (3) @(negedge clk);
        #1 chk(err_parity, "R11 parity flag sticky", err_parity, 1);
        clear_errors();
        #1 chk(!err_parity, "R11 parity flag cleared", err_parity, 0);
    endtask

    // R3 slave side: bad parity ignored
    task automatic t_parity_off_slave();
        start_frame(1'b0, 6'd0, 2'd2, 4'd1, 1'b0, 1'b0, 1'b1);
        rx_step(ref_pid(6'h09) ^ 8'hC0, 1'b0, "R3 unchecked pid");
        done_step("R3 slave ignore");
        chk(!err_parity, "R3 no parity error", err_parity, 0);
    endtask

    // R12
    task automatic t_abort();
        logic [7:0] d [8];
        fill(d, 0);
        start_frame(1'b1, 6'h01, 2'd0, 4'd3, 1'b0, 1'b0, 1'b0);
        tx_step(ref_pid(6'h01), "R12 pid");
        pub_step(d[0], "R12 first data");
        @(negedge clk); pub_valid = 1'b1; abort = 1'b1;
        @(posedge clk); #1 abort = 1'b0;
        @(negedge clk); #1;
        chk(!tx_valid && !pub_ready && !rx_ready && !frame_done, "R12 idle after abort",
            {tx_valid, pub_ready, rx_ready, frame_done}, 0);
        @(negedge clk); pub_valid = 1'b0; #1;
        chk(!frame_done, "R12 no done", frame_done, 0);
    endtask

    // R11 set wins over clear
    task automatic t_set_wins();
        start_frame(1'b0, 6'd0, 2'd1, 4'd1, 1'b1, 1'b0, 1'b0);
        rx_step(ref_pid(6'h22), 1'b0, "R11 pid");
        rx_step(8'h10, 1'b1, "R11 data");
        @(negedge clk); rx_data = 8'h00; rx_valid = 1'b1; err_clear = 1'b1;
        @(negedge clk); rx_valid = 1'b0; err_clear = 1'b0; #1;
        chk(err_csum && frame_done, "R11 set wins over clear", {err_csum, frame_done}, 2'b11);
        clear_errors();
        #1 chk(!err_csum, "R11 csum cleared", err_csum, 0);
    endtask

    initial begin
        rst = 1'b1; frame_start = 0; abort = 0; is_master = 0; id_in = 0; node_act = 0;
        byte_cnt = 1; csum_classic = 0; csum_off = 0; parity_off = 0; tx_ready = 1;
        rx_data = 0; rx_valid = 0; pub_data = 0; pub_valid = 0; err_clear = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        run_pub(6'h3C, 4'd2, 2, 1'b0, 1'b0, 1'b0, "R5 R6 publish enhanced");
        run_pub(6'h11, 4'd8, 8, 1'b1, 1'b0, 1'b0, "R6 publish classic");
        run_pub(6'h07, 4'd0, 1, 1'b0, 1'b0, 1'b0, "R13 count zero");
        run_pub(6'h33, 4'd4, 4, 1'b0, 1'b1, 1'b0, "R8 publish no csum");
        run_pub(6'h1F, 4'd3, 3, 1'b0, 1'b0, 1'b1, "R3 publish parity off");
        run_sub(6'h05, 4'd4, 4, 1'b0, 1'b0, 1'b0, "R7 subscribe enhanced");
        run_sub(6'h3E, 4'd15, 8, 1'b1, 1'b0, 1'b0, "R13 count over max");
        run_sub(6'h28, 4'd3, 3, 1'b0, 1'b0, 1'b1, "R7 bad checksum");
        clear_errors();
        #1 chk(!err_csum, "R11 csum cleared by err_clear", err_csum, 0);
        run_sub(6'h12, 4'd2, 2, 1'b0, 1'b1, 1'b0, "R8 subscribe no csum");
        t_pid_stall();
        t_bad_parity();
        t_parity_off_slave();
        t_abort();
        t_set_wins();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule